// File: doc/BRIEF.md
# SDRAM Clock-Enable Power-State Tracker

This block follows a DDR SDRAM device's power state through its clock-enable pin and its command bus. At every rising clock edge it compares the clock-enable level with the level seen at the edge before. It then combines that pair with the command decoded at the current edge and with a flag that says whether any bank is open. From these it picks the next state. The possible states are: all banks idle, bank active, precharge power-down, active power-down, self refresh, and a recovery window that follows self-refresh exit.

A controller model or a protocol monitor places the block beside the command path. It gets two results from it. The first is a one-cycle flag for every edge whose pairing of state, clock-enable history and command is not permitted. The second is a level that says whether a READ may be issued. After self refresh the device needs a parameterised number of cycles, 200 by default, before its DLL is locked. A down-counter holds the READ level low for that interval. During the interval only no-operation or deselect commands with clock-enable high are allowed.

Top module: `cke_power_fsm`

## Requirements
- R1: While reset is asserted and after it is released, `pwr_state` is 0 (all idle), `illegal` is 0 and `read_ok` is 1. The clock-enable seen at the previous edge is taken as high at reset.
- R2: State codes are 0 all idle, 1 bank active, 2 precharge power-down, 3 active power-down, 4 self refresh, 5 exit recovery. Command codes are 0 NOP, 1 DESELECT, 2 AUTO REFRESH, 3 READ, 4 ACTIVE, 5 PRECHARGE; 6 and 7 mean any other command. In state 0 or 1, with clock-enable high at both edges, every command is legal and the next state is 1 if `bank_open` is set and 0 otherwise.
- R3: In state 0 or 1, a high-to-low clock-enable with NOP or DESELECT enters state 2 when `bank_open` is 0 and state 3 when it is 1.
- R4: In state 0 or 1, a high-to-low clock-enable with AUTO REFRESH and `bank_open` at 0 enters state 4.
- R5: Any other combination in state 0 or 1 is illegal and leaves the state unchanged. This covers a high-to-low edge with another command, AUTO REFRESH while a bank is open, and a clock-enable that was low at the previous edge.
- R6: In states 2, 3 and 4, clock-enable low at both edges keeps the state under any command, without flagging.
- R7: In state 2 or 3, a low-to-high clock-enable with NOP or DESELECT exits to state 0 or 1 respectively. Any other command at that edge, or clock-enable high at the previous edge, is illegal and keeps the state.
- R8: In state 4, a low-to-high clock-enable with NOP or DESELECT enters state 5. Any other command at that edge, or clock-enable high at the previous edge, is illegal and keeps state 4.
- R9: State 5 lasts exactly `XSR_CYCLES` clock edges and then returns to state 0. `read_ok` is 1 only in states 0 and 1.
- R10: In state 5, any edge whose command is not NOP or DESELECT, or whose clock-enable is low, is illegal. The countdown continues regardless.
- R11: `illegal` is registered. It is high for exactly the one cycle that follows each offending edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all decisions happen on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | input | 1 | Device clock-enable level at this edge |
| cmd | input | 3 | Decoded command code (see R2) |
| bank_open | input | 1 | High when at least one bank is open |
| pwr_state | output | 3 | Current power state code (see R2) |
| illegal | output | 1 | Previous edge was a forbidden combination |
| read_ok | output | 1 | READ may be issued now |

## Verification
The assertions check the following on every cycle: the power-down and self-refresh hold rule, both idle-state entries, flagging of a non-NOP command or a low clock-enable during recovery, and the one-step decrement of the recovery counter. The bench's scenarios are the only place that shows the length of the recovery window, the return to idle at its end, the READ level as it sits across that window, and the exits from power-down to the right operating state. They also show that an illegal edge leaves the state untouched. A reference model in the bench follows long random runs of clock-enable toggles and command mixes for these.

// File: rtl/cke_power_pkg.sv
package cke_power_pkg;
  typedef enum logic [2:0] {
    PS_IDLE = 3'd0,
    PS_ACT  = 3'd1,
    PS_PPD  = 3'd2,
    PS_APD  = 3'd3,
    PS_SREF = 3'd4,
    PS_SRX  = 3'd5
  } pstate_e;

  localparam logic [2:0] CMD_NOP   = 3'd0;
  localparam logic [2:0] CMD_DESEL = 3'd1;
  localparam logic [2:0] CMD_AREF  = 3'd2;
  localparam logic [2:0] CMD_READ  = 3'd3;

  function automatic logic is_quiet(input logic [2:0] c);
    return (c == CMD_NOP) || (c == CMD_DESEL);
  endfunction
endpackage

// File: rtl/cke_history.sv
module cke_history (
  input  logic clk,
  input  logic rst_n,
  input  logic cke,
  output logic cke_q
);
  // Level of clock-enable at the previous edge; high out of reset.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cke_q <= 1'b1;
    else        cke_q <= cke;
  end
endmodule

// File: rtl/xsr_timer.sv
module xsr_timer #(
  parameter int XSR_CYCLES = 200,
  localparam int CNT_W = $clog2(XSR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  output logic last
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (load)       cnt <= CNT_W'(XSR_CYCLES);
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign last = (cnt == CNT_W'(1));

  // R9: the recovery count drops by one per edge while running.
  p_count_down_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !load) |=> (cnt == $past(cnt) - 1'b1));
endmodule

// File: rtl/pwr_next.sv
module pwr_next
  import cke_power_pkg::*;
(
  input  pstate_e    cur,
  input  logic       cke_q,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       bank_open,
  input  logic       tmr_last,
  output pstate_e    nxt,
  output logic       bad,
  output logic       tmr_load
);
  logic quiet;
  assign quiet = is_quiet(cmd);

  always_comb begin
    nxt      = cur;
    bad      = 1'b0;
    tmr_load = 1'b0;
    unique case (cur)
      PS_IDLE, PS_ACT: begin
        if (!cke_q)                      bad = 1'b1;
        else if (cke)                    nxt = bank_open ? PS_ACT : PS_IDLE;
        else if (quiet)                  nxt = bank_open ? PS_APD : PS_PPD;
        else if (cmd == CMD_AREF && !bank_open) nxt = PS_SREF;
        else                             bad = 1'b1;
      end
      PS_PPD, PS_APD, PS_SREF: begin
        if (cke_q)                       bad = 1'b1;
        else if (!cke)                   nxt = cur;
        else if (!quiet)                 bad = 1'b1;
        else if (cur == PS_PPD)          nxt = PS_IDLE;
        else if (cur == PS_APD)          nxt = PS_ACT;
        else begin
          nxt      = PS_SRX;
          tmr_load = 1'b1;
        end
      end
      PS_SRX: begin
        bad = !(cke && quiet);
        if (tmr_last) nxt = PS_IDLE;
      end
      default: begin
        nxt = PS_IDLE;
        bad = 1'b1;
      end
    endcase
  end
endmodule

// File: rtl/cke_power_fsm.sv
module cke_power_fsm
  import cke_power_pkg::*;
#(
  parameter int XSR_CYCLES = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cke,
  input  logic [2:0] cmd,
  input  logic       bank_open,
  output logic [2:0] pwr_state,
  output logic       illegal,
  output logic       read_ok
);
  pstate_e state, nxt;
  logic    cke_q, bad, tmr_load, tmr_last;

  cke_history u_hist (.clk(clk), .rst_n(rst_n), .cke(cke), .cke_q(cke_q));

  xsr_timer #(.XSR_CYCLES(XSR_CYCLES)) u_tmr (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .last(tmr_last));

  pwr_next u_next (
    .cur(state), .cke_q(cke_q), .cke(cke), .cmd(cmd), .bank_open(bank_open),
    .tmr_last(tmr_last), .nxt(nxt), .bad(bad), .tmr_load(tmr_load));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= PS_IDLE;
      illegal <= 1'b0;
    end else begin
      state   <= nxt;
      illegal <= bad;
    end
  end

  assign pwr_state = state;
  assign read_ok   = (state == PS_IDLE) || (state == PS_ACT);

  // R6: low clock-enable at both edges holds every low-power state.
  p_lowpower_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_PPD || state == PS_APD || state == PS_SREF) && !cke_q && !cke)
      |=> (pwr_state == $past(pwr_state) && !illegal));

  // R3: quiet command on falling clock-enable with no open bank.
  p_ppd_entry_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_IDLE || state == PS_ACT) && cke_q && !cke && is_quiet(cmd) && !bank_open)
      |=> (pwr_state == 3'd2));

  // R4: auto refresh on falling clock-enable enters self refresh.
  p_sref_entry_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_IDLE || state == PS_ACT) && cke_q && !cke && cmd == CMD_AREF && !bank_open)
      |=> (pwr_state == 3'd4));

  // R10: anything but a quiet command with clock-enable high during recovery.
  p_srx_misuse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == PS_SRX && !(cke && is_quiet(cmd))) |=> illegal);
endmodule

// File: tb/cke_power_fsm_bench.sv
module cke_power_fsm_bench;
  localparam int XSR = 200;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cke = 1'b1;
  logic [2:0] cmd = 3'd0;
  logic       bank_open = 1'b0;
  logic [2:0] pwr_state;
  logic       illegal, read_ok;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  cke_power_fsm #(.XSR_CYCLES(XSR)) u_cke_power_fsm (
    .clk(clk), .rst_n(rst_n), .cke(cke), .cmd(cmd), .bank_open(bank_open),
    .pwr_state(pwr_state), .illegal(illegal), .read_ok(read_ok));

  // Reference model
  int    m_state, m_cnt;
  logic  m_prev, m_ill;
  string m_tag;

  function automatic bit quiet_cmd(input logic [2:0] c);
    return c == 3'd0 || c == 3'd1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_state <= 0; m_prev <= 1'b1; m_cnt <= 0; m_ill <= 1'b0; m_tag <= "R1";
    end else begin : model_step
      int ns; bit b; string t; int nc;
      ns = m_state; b = 0; t = "R2"; nc = (m_cnt > 0) ? m_cnt - 1 : 0;
      if (m_state <= 1) begin
        if (!m_prev) begin b = 1; t = "R5"; end
        else if (cke) begin ns = bank_open ? 1 : 0; t = "R2"; end
        else if (quiet_cmd(cmd)) begin ns = bank_open ? 3 : 2; t = "R3"; end
        else if (cmd == 3'd2 && !bank_open) begin ns = 4; t = "R4"; end
        else begin b = 1; t = "R5"; end
      end else if (m_state <= 4) begin
        t = (m_state == 4) ? "R8" : "R7";
        if (m_prev) b = 1;
        else if (!cke) t = "R6";
        else if (!quiet_cmd(cmd)) b = 1;
        else if (m_state == 2) ns = 0;
        else if (m_state == 3) ns = 1;
        else begin ns = 5; nc = XSR; end
      end else begin
        t = "R10";
        if (!(cke && quiet_cmd(cmd))) b = 1;
        if (m_cnt == 1) begin ns = 0; t = "R9"; end
      end
      m_state <= ns; m_ill <= b; m_tag <= t; m_prev <= cke; m_cnt <= nc;
    end
  end

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    chk(m_tag, "pwr_state", int'(pwr_state), m_state);
    chk(m_tag == "R11" ? "R11" : {m_tag, "/R11"}, "illegal", int'(illegal), int'(m_ill));
    chk("R9", "read_ok", int'(read_ok), (m_state <= 1) ? 1 : 0);
  endtask

  task automatic step(input logic k, input logic [2:0] c, input logic bo);
    @(negedge clk);
    compare_all();
    cke = k; cmd = c; bank_open = bo;
  endtask

  bit done = 0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    // R1: reset values
    chk("R1", "pwr_state", int'(pwr_state), 0);
    chk("R1", "illegal", int'(illegal), 0);
    chk("R1", "read_ok", int'(read_ok), 1);
    rst_n = 1'b1;
    // R2: operating traffic follows bank_open
    step(1, 3'd4, 1); step(1, 3'd3, 1); step(1, 3'd5, 0); step(1, 3'd0, 0);
    // R3 precharge power-down, R6 hold, R7 exit
    step(0, 3'd1, 0); step(0, 3'd3, 0); step(0, 3'd6, 0); step(1, 3'd0, 0);
    // R3 active power-down, R7 bad exit then good exit
    step(1, 3'd4, 1); step(0, 3'd0, 1); step(0, 3'd2, 1); step(1, 3'd3, 1);
    step(0, 3'd0, 1); step(0, 3'd0, 1); step(1, 3'd1, 1); step(1, 3'd0, 1);
    // R5: auto refresh with open bank, then READ at falling edge
    step(1, 3'd5, 0); step(0, 3'd2, 1); step(1, 3'd0, 0); step(0, 3'd3, 0);
    step(1, 3'd0, 0); step(1, 3'd0, 0);
    // R4 self refresh, R8 bad exit, good exit, R9/R10 recovery
    step(0, 3'd2, 0); step(0, 3'd4, 0); step(1, 3'd3, 0);
    step(0, 3'd0, 0); step(0, 3'd0, 0); step(1, 3'd0, 0);
    for (int i = 0; i < XSR - 1; i++) begin
      if (i == 50)       step(1, 3'd3, 0);   // R10 READ too early
      else if (i == 90)  step(0, 3'd0, 0);   // R10 low clock-enable
      else               step(1, (i % 2) ? 3'd1 : 3'd0, 0);
    end
    step(1, 3'd3, 0); step(1, 3'd3, 0); step(1, 3'd0, 0);
    // Constrained random traffic
    for (int i = 0; i < 6000; i++) begin
      logic k; logic [2:0] c; int r;
      r = $urandom_range(0, 99);
      k = ($urandom_range(0, 7) == 0) ? ~cke : cke;
      if (r < 55)      c = 3'($urandom_range(0, 1));
      else if (r < 70) c = 3'd2;
      else             c = 3'($urandom_range(0, 7));
      step(k, c, ($urandom_range(0, 3) == 0) ? ~bank_open : bank_open);
    end
    step(1, 3'd0, 0);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule